// File: doc/BRIEF.md
# Multi-Warp Issue Scheduler

This block picks at most one instruction per cycle from the warps resident on one compute unit. Each warp slot keeps its state in place. Switching from one warp to another therefore costs no cycle, and no state is saved or restored. Every slot presents its next instruction as a kind code, a destination register tag and two source register tags. Each warp has its own scoreboard. When an arithmetic instruction issues, the scoreboard holds its destination busy for a fixed result latency. A later instruction from the same warp that names that register waits until the latency has run out.

Warps are picked round-robin, starting at the slot after the one that issued last. This moves issue away from the warp that just issued whenever another warp is ready, and so hides the pipeline latency. A warp that issues a block barrier stops issuing until every resident warp of its block has also reached the barrier. A warp that issues an exit leaves its slot free and counts as arrived for later barriers. An outside dispatcher fills slots through the launch pins, one slot per cycle, and gives each warp a block number.

The instruction inputs form a valid/ready stream for each slot. `inst_ready[w]` is a combinational grant. The instruction of slot w is consumed in a cycle where `inst_valid[w]` and `inst_ready[w]` are both high. Once a slot raises valid, it must hold valid and all its fields steady until it is granted. The issue outputs have no back-pressure: the downstream pipeline takes every issue. A launch may only target a slot that is not resident.

Top module: `wsched_issue`

## Requirements
- R1: After reset no slot is resident, `idle` is high, `issue_valid` is low and `inst_ready` is all zero, even with every `inst_valid` high.
- R2: A slot is granted only if it is resident, presents a valid instruction, is not waiting at a barrier and has no scoreboard hazard. `issue_warp`, `issue_kind` and `issue_dst` then carry that slot's index, kind and destination.
- R3: Kind codes: 2'b00 arithmetic, 2'b01 barrier, 2'b10 exit, 2'b11 no-op. Only arithmetic instructions check their tags or write the scoreboard. If an arithmetic instruction from warp w issues in cycle t with destination d, no arithmetic instruction of warp w whose destination or either source equals d can issue before cycle t+RESULT_LAT. With no other hazard, it issues exactly in that cycle.
- R4: Among eligible slots, the grant goes to the first one found when searching upward from (last issued index + 1), wrapping around. The same warp issues in consecutive cycles only when it is the only eligible slot.
- R5: At most one `inst_ready` bit is high in any cycle, and it equals the one-hot index of `issue_warp` whenever `issue_valid` is high.
- R6: `idle` is high and `issue_valid` is low exactly in the cycles where no slot is eligible.
- R7: A warp that issues a barrier stays ineligible until every resident warp with the same block number has also issued a barrier. Warps of other blocks keep issuing meanwhile. It becomes eligible two cycles after the cycle in which the last warp of its block arrives.
- R8: Issuing an exit clears the slot's residency from the next cycle. A valid instruction presented on that slot is then never granted, and the exited warp no longer holds back a barrier of its block.
- R9: A launch makes the slot resident from the next cycle, with the given block number, no pending barrier and an all-clear scoreboard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Fill one slot this cycle |
| launch_warp | input | WID_W | Slot to fill |
| launch_block | input | BLK_W | Block number of the new warp |
| inst_valid | input | NUM_WARPS | Per-slot instruction present |
| inst_kind | input | NUM_WARPS×2 | Per-slot instruction kind |
| inst_dst | input | NUM_WARPS×TAG_W | Per-slot destination tag |
| inst_src0 | input | NUM_WARPS×TAG_W | Per-slot first source tag |
| inst_src1 | input | NUM_WARPS×TAG_W | Per-slot second source tag |
| inst_ready | output | NUM_WARPS | One-hot grant, ready of each slot's stream |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Issuing slot |
| issue_kind | output | 2 | Kind of the issued instruction |
| issue_dst | output | TAG_W | Destination of the issued instruction |
| idle | output | 1 | No slot eligible this cycle |

## Verification
A single warp running a dependent chain measures the result latency down to the exact cycle. Several warps with no dependences show the strict rotation, and the same warp issuing back-to-back when alone. Directed barrier and exit sequences across two blocks show which warps are held, which keep issuing, and when a waiting warp is released, including release by a warp that exits. A long random mix then compares every grant against a behavioural model each cycle. That mix uses arithmetic with heavily reused tags, barriers, exits and relaunches into random blocks, so it exposes faults in priority order, in hazard timing and in the clearing of state at launch.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic [1:0] {
    K_ALU  = 2'b00,
    K_BAR  = 2'b01,
    K_EXIT = 2'b10,
    K_NOP  = 2'b11
  } kind_e;
endpackage

// File: rtl/wsched_sb.sv
// Per-warp register scoreboard: one down-counter per register tag.
module wsched_sb #(
  parameter int TAG_W = 4,
  parameter int LAT   = 12,
  localparam int REGS = 1 << TAG_W,
  localparam int CW   = (LAT > 2) ? $clog2(LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             chk_en,
  input  logic [TAG_W-1:0] t_dst,
  input  logic [TAG_W-1:0] t_s0,
  input  logic [TAG_W-1:0] t_s1,
  output logic             hazard
);
  logic [CW-1:0] cnt [REGS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < REGS; r++) begin
      if (!rst_n || clear)
        cnt[r] <= '0;
      else if (wr_en && (int'(wr_tag) == r))
        cnt[r] <= CW'(LAT - 1);
      else if (cnt[r] != '0)
        cnt[r] <= cnt[r] - 1'b1;
    end
  end

  always_comb begin
    hazard = chk_en && ((cnt[t_dst] != '0) || (cnt[t_s0] != '0) || (cnt[t_s1] != '0));
  end
endmodule

// File: rtl/wsched_bar.sv
// Block barrier tracking: a waiting warp is released when all resident
// warps of its block are waiting.
module wsched_bar #(
  parameter int N    = 8,
  parameter int BW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         resident,
  input  logic [N-1:0][BW-1:0] blk,
  input  logic [N-1:0]         set_bar,
  input  logic [N-1:0]         clr,
  output logic [N-1:0]         at_bar
);
  logic [N-1:0] rel;

  always_comb begin
    for (int w = 0; w < N; w++) begin
      rel[w] = at_bar[w];
      for (int j = 0; j < N; j++) begin
        if (resident[j] && !at_bar[j] && (blk[j] == blk[w]))
          rel[w] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) at_bar <= '0;
    else        at_bar <= ((at_bar & ~rel) | set_bar) & ~clr;
  end
endmodule

// File: rtl/wsched_rr.sv
// Round-robin pick: first eligible slot after the last issued one.
module wsched_rr #(
  parameter int N     = 8,
  parameter int WID_W = 3
) (
  input  logic [N-1:0]     elig,
  input  logic [WID_W-1:0] last,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [WID_W-1:0] idx
);
  always_comb begin
    int c;
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last) + k) % N;
      if (!any && elig[c]) begin
        any      = 1'b1;
        idx      = WID_W'(c);
        grant[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsched_issue.sv
module wsched_issue
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS  = 8,
  parameter int TAG_W      = 4,
  parameter int RESULT_LAT = 12,
  parameter int BLK_W      = 2,
  localparam int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                launch_valid,
  input  logic [WID_W-1:0]                    launch_warp,
  input  logic [BLK_W-1:0]                    launch_block,
  input  logic [NUM_WARPS-1:0]                inst_valid,
  input  logic [NUM_WARPS-1:0][1:0]           inst_kind,
  input  logic [NUM_WARPS-1:0][TAG_W-1:0]     inst_dst,
  input  logic [NUM_WARPS-1:0][TAG_W-1:0]     inst_src0,
  input  logic [NUM_WARPS-1:0][TAG_W-1:0]     inst_src1,
  output logic [NUM_WARPS-1:0]                inst_ready,
  output logic                                issue_valid,
  output logic [WID_W-1:0]                    issue_warp,
  output logic [1:0]                          issue_kind,
  output logic [TAG_W-1:0]                    issue_dst,
  output logic                                idle
);
  logic [NUM_WARPS-1:0]            resident_q, launch_hot, at_bar, hazard, eligible;
  logic [NUM_WARPS-1:0]            set_bar, exit_hit, alu_hit;
  logic [NUM_WARPS-1:0][BLK_W-1:0] blk_q;
  logic [WID_W-1:0]                last_q, pick_idx;
  logic                            pick_any;

  always_comb begin
    launch_hot = '0;
    if (launch_valid) launch_hot[launch_warp] = 1'b1;
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic is_alu;
    assign is_alu = (inst_kind[w] == K_ALU);

    wsched_sb #(.TAG_W(TAG_W), .LAT(RESULT_LAT)) sb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (launch_hot[w]),
      .wr_en  (alu_hit[w]),
      .wr_tag (inst_dst[w]),
      .chk_en (is_alu),
      .t_dst  (inst_dst[w]),
      .t_s0   (inst_src0[w]),
      .t_s1   (inst_src1[w]),
      .hazard (hazard[w])
    );

    assign eligible[w] = resident_q[w] & inst_valid[w] & ~at_bar[w] & ~hazard[w];
    assign alu_hit[w]  = inst_ready[w] & is_alu;
    assign set_bar[w]  = inst_ready[w] & (inst_kind[w] == K_BAR);
    assign exit_hit[w] = inst_ready[w] & (inst_kind[w] == K_EXIT);
  end

  wsched_rr #(.N(NUM_WARPS), .WID_W(WID_W)) rr_i (
    .elig  (eligible),
    .last  (last_q),
    .grant (inst_ready),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  wsched_bar #(.N(NUM_WARPS), .BW(BLK_W)) bar_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .resident (resident_q),
    .blk      (blk_q),
    .set_bar  (set_bar),
    .clr      (launch_hot),
    .at_bar   (at_bar)
  );

  always_comb begin
    issue_valid = pick_any;
    idle        = ~pick_any;
    issue_warp  = pick_idx;
    issue_kind  = pick_any ? inst_kind[pick_idx] : 2'b00;
    issue_dst   = pick_any ? inst_dst[pick_idx]  : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resident_q <= '0;
      blk_q      <= '0;
      last_q     <= WID_W'(NUM_WARPS - 1);
    end else begin
      resident_q <= (resident_q & ~exit_hit) | launch_hot;
      if (launch_valid) blk_q[launch_warp] <= launch_block;
      if (pick_any)     last_q <= pick_idx;
    end
  end
endmodule

// File: rtl/wsched_issue_chk.sv
module wsched_issue_chk #(
  parameter int NUM_WARPS = 8,
  parameter int TAG_W     = 4,
  parameter int WID_W     = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            launch_valid,
  input logic [WID_W-1:0]                launch_warp,
  input logic [NUM_WARPS-1:0]            inst_valid,
  input logic [NUM_WARPS-1:0][TAG_W-1:0] inst_src0,
  input logic [NUM_WARPS-1:0][TAG_W-1:0] inst_src1,
  input logic [NUM_WARPS-1:0]            inst_ready,
  input logic                            issue_valid,
  input logic [WID_W-1:0]                issue_warp,
  input logic [1:0]                      issue_kind,
  input logic [TAG_W-1:0]                issue_dst,
  input logic                            idle
);
  logic [TAG_W-1:0] cur_s0, cur_s1;
  assign cur_s0 = inst_src0[issue_warp];
  assign cur_s1 = inst_src1[issue_warp];

  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inst_ready));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!issue_valid && inst_ready == '0));

  p_grant_has_inst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (inst_valid[issue_warp] && inst_ready[issue_warp]));

  p_result_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == 2'b00 && !launch_valid) |=>
      !(issue_valid && issue_kind == 2'b00 && issue_warp == $past(issue_warp) &&
        (cur_s0 == $past(issue_dst) || cur_s1 == $past(issue_dst) ||
         issue_dst == $past(issue_dst))));

  p_barrier_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == 2'b01 && !launch_valid) |=>
      !(issue_valid && issue_warp == $past(issue_warp)));

  p_exit_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == 2'b10 &&
     !(launch_valid && launch_warp == issue_warp)) |=>
      !(issue_valid && issue_warp == $past(issue_warp)));
endmodule

bind wsched_issue wsched_issue_chk #(
  .NUM_WARPS (NUM_WARPS),
  .TAG_W     (TAG_W),
  .WID_W     (WID_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_warp  (launch_warp),
  .inst_valid   (inst_valid),
  .inst_src0    (inst_src0),
  .inst_src1    (inst_src1),
  .inst_ready   (inst_ready),
  .issue_valid  (issue_valid),
  .issue_warp   (issue_warp),
  .issue_kind   (issue_kind),
  .issue_dst    (issue_dst),
  .idle         (idle)
);

// File: tb/wsched_issue_tb_top.sv
module wsched_issue_tb_top;
  localparam int N   = 8;
  localparam int TW  = 4;
  localparam int LAT = 12;
  localparam int BW  = 2;
  localparam int WW  = 3;
  localparam int NR  = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                  launch_valid = 1'b0;
  logic [WW-1:0]         launch_warp  = '0;
  logic [BW-1:0]         launch_block = '0;
  logic [N-1:0]          inst_valid;
  logic [N-1:0][1:0]     inst_kind;
  logic [N-1:0][TW-1:0]  inst_dst, inst_src0, inst_src1;
  logic [N-1:0]          inst_ready;
  logic                  issue_valid, idle;
  logic [WW-1:0]         issue_warp;
  logic [1:0]            issue_kind;
  logic [TW-1:0]         issue_dst;

  wsched_issue #(.NUM_WARPS(N), .TAG_W(TW), .RESULT_LAT(LAT), .BLK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_warp(launch_warp),
    .launch_block(launch_block), .inst_valid(inst_valid), .inst_kind(inst_kind),
    .inst_dst(inst_dst), .inst_src0(inst_src0), .inst_src1(inst_src1),
    .inst_ready(inst_ready), .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_kind(issue_kind), .issue_dst(issue_dst), .idle(idle)
  );

  // Presented instruction per slot
  bit v[N];
  bit hold[N];
  int k[N], d[N], s0[N], s1[N];

  always_comb begin
    for (int w = 0; w < N; w++) begin
      inst_valid[w] = v[w];
      inst_kind[w]  = 2'(k[w]);
      inst_dst[w]   = TW'(d[w]);
      inst_src0[w]  = TW'(s0[w]);
      inst_src1[w]  = TW'(s1[w]);
    end
  end

  // Behavioural model state
  bit m_res[N];
  bit m_bar[N];
  int m_blk[N];
  int m_free_at[N][NR];
  int m_last = N - 1;
  int cyc = 0;
  int exp_w, act_w;
  bit autogen = 1'b0;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic bit elig(int w);
    if (!m_res[w] || !v[w] || m_bar[w]) return 1'b0;
    if (k[w] != 0) return 1'b1;
    return (m_free_at[w][d[w]] <= cyc) && (m_free_at[w][s0[w]] <= cyc) &&
           (m_free_at[w][s1[w]] <= cyc);
  endfunction

  task automatic new_inst(int w);
    int r;
    r = $urandom % 100;
    k[w]  = (r < 5) ? 1 : (r < 8) ? 2 : (r < 15) ? 3 : 0;
    d[w]  = $urandom % 4;
    s0[w] = $urandom % 4;
    s1[w] = $urandom % 6;
    v[w]  = ($urandom % 5) != 0;
  endtask

  // One clock: compare at mid-cycle, then advance the model after the edge.
  task automatic step();
    bit rel[N];
    logic [N-1:0] er;
    int c;
    #2;
    exp_w = -1;
    for (int kk = 1; kk <= N; kk++) begin
      c = (m_last + kk) % N;
      if (exp_w < 0 && elig(c)) exp_w = c;
    end
    er = '0;
    if (exp_w >= 0) er[exp_w] = 1'b1;
    chk(inst_ready == er, "R5 grant vector", int'(inst_ready), int'(er));
    chk(idle == (exp_w < 0) && issue_valid == (exp_w >= 0), "R6 idle/valid", int'(idle), int'(exp_w < 0));
    if (exp_w >= 0)
      chk(issue_valid && int'(issue_warp) == exp_w && int'(issue_kind) == k[exp_w] &&
          int'(issue_dst) == d[exp_w], "R2 issued warp", int'(issue_warp), exp_w);
    act_w = issue_valid ? int'(issue_warp) : -1;
    @(posedge clk);
    #1;
    for (int w = 0; w < N; w++) begin
      rel[w] = m_bar[w];
      for (int j = 0; j < N; j++)
        if (m_res[j] && !m_bar[j] && m_blk[j] == m_blk[w]) rel[w] = 1'b0;
    end
    for (int w = 0; w < N; w++) if (rel[w]) m_bar[w] = 1'b0;
    if (exp_w >= 0) begin
      if (k[exp_w] == 0) m_free_at[exp_w][d[exp_w]] = cyc + LAT;
      if (k[exp_w] == 1) m_bar[exp_w] = 1'b1;
      if (k[exp_w] == 2) m_res[exp_w] = 1'b0;
      m_last = exp_w;
    end
    if (launch_valid) begin
      m_res[launch_warp] = 1'b1;
      m_bar[launch_warp] = 1'b0;
      m_blk[launch_warp] = int'(launch_block);
      for (int r = 0; r < NR; r++) m_free_at[launch_warp][r] = 0;
    end
    cyc++;
    launch_valid = 1'b0;
    if (autogen) begin
      for (int w = 0; w < N; w++)
        if (w == exp_w || !v[w]) new_inst(w);
      c = $urandom % N;
      if (!m_res[c] && ($urandom % 3) == 0) begin
        launch_valid = 1'b1;
        launch_warp  = WW'(c);
        launch_block = BW'($urandom % 2);
      end
    end else if (exp_w >= 0 && !hold[exp_w]) begin
      v[exp_w] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic do_launch(int w, int b);
    launch_valid = 1'b1;
    launch_warp  = WW'(w);
    launch_block = BW'(b);
    step();
  endtask

  task automatic run_until(int w, string req, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (act_w != w && n < 200);
    chk(act_w == w, req, act_w, w);
  endtask

  task automatic count_steps(int steps, int w, output int hits);
    hits = 0;
    for (int i = 0; i < steps; i++) begin
      step();
      if (act_w == w) hits++;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, hits, hits2, prev;
    for (int w = 0; w < N; w++) begin
      v[w] = 1'b1; hold[w] = 1'b0; k[w] = 3; d[w] = 0; s0[w] = 0; s1[w] = 0;
      m_res[w] = 1'b0; m_bar[w] = 1'b0; m_blk[w] = 0;
      for (int r = 0; r < NR; r++) m_free_at[w][r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing resident after reset although every slot presents
    #2;
    chk(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    chk(inst_ready == '0 && !issue_valid, "R1 no grant after reset", int'(inst_ready), 0);
    @(negedge clk);
    step();
    for (int w = 0; w < N; w++) v[w] = 1'b0;

    // R3: dependent chain on one warp
    do_launch(0, 0);
    v[0] = 1'b1; k[0] = 0; d[0] = 1; s0[0] = 2; s1[0] = 2;
    run_until(0, "R3 producer issue", n);
    v[0] = 1'b1; k[0] = 0; d[0] = 3; s0[0] = 1; s1[0] = 2;
    run_until(0, "R3 consumer issue", n);
    chk(n == LAT, "R3 result latency", n, LAT);

    // R4: rotation across three warps, then a lone warp
    do_launch(1, 0);
    do_launch(2, 1);
    for (int w = 0; w < 3; w++) begin v[w] = 1'b1; k[w] = 3; hold[w] = 1'b1; end
    step();
    prev = act_w;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(act_w == (prev + 1) % 3, "R4 rotation", act_w, (prev + 1) % 3);
      prev = act_w;
    end
    v[1] = 1'b0; v[2] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(act_w == 0, "R4 lone warp back-to-back", act_w, 0);
    end

    // R7: barrier in block 0 (warps 0,1); warp 2 in block 1
    hold[0] = 1'b0; k[0] = 1; v[0] = 1'b1;
    v[1] = 1'b1; v[2] = 1'b1;
    run_until(0, "R7 barrier issue", n);
    v[0] = 1'b1; k[0] = 3; hold[0] = 1'b1;
    count_steps(10, 0, hits);
    chk(hits == 0, "R7 waiting warp held", hits, 0);
    v[0] = 1'b0;
    count_steps(4, 2, hits2);
    chk(hits2 > 0, "R7 other block unaffected", hits2, 1);
    v[0] = 1'b1;
    hold[1] = 1'b0; k[1] = 1; v[1] = 1'b1;
    run_until(1, "R7 last arrival", n);
    count_steps(4, 0, hits);
    chk(hits > 0, "R7 release", hits, 1);

    // R8: exit releases the barrier and frees the slot
    hold[0] = 1'b0; k[0] = 1; v[0] = 1'b1;
    run_until(0, "R8 barrier before exit", n);
    v[0] = 1'b1; k[0] = 3; hold[0] = 1'b1;
    k[1] = 2; v[1] = 1'b1; hold[1] = 1'b0;
    run_until(1, "R8 exit issue", n);
    count_steps(4, 0, hits);
    chk(hits > 0, "R8 exit counts as arrived", hits, 1);
    v[1] = 1'b1; k[1] = 3; hold[1] = 1'b1;
    count_steps(6, 1, hits);
    chk(hits == 0, "R8 exited slot ignored", hits, 0);

    // R9: relaunch into the freed slot
    do_launch(1, 0);
    count_steps(6, 1, hits);
    chk(hits > 0, "R9 relaunched warp issues", hits, 1);

    // R6: nothing presented
    for (int w = 0; w < N; w++) begin v[w] = 1'b0; hold[w] = 1'b0; end
    for (int i = 0; i < 3; i++) begin
      #2;
      chk(idle && inst_ready == '0, "R6 idle with no instructions", int'(idle), 1);
      @(negedge clk);
      step();
    end

    // Random mix against the model (R2, R3, R5, R6, R7, R8, R9)
    autogen = 1'b1;
    for (int i = 0; i < 4000; i++) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule